// File: doc/BRIEF.md
# Configurable Interleaved Converter Data Port

This block is the digital side of a two-channel converter data port. Receive samples (channel A and channel B from a pair of converters) and transmit samples (for a pair of output converters) move across two 12-bit pin groups, called the high bus and the low bus. The port works in one of three modes, chosen at run time. The first is a half-duplex mode where a single 24-bit word carries both channels at once. The second is a half-duplex mode where both channels take turns on the high bus, channel A first. The third is a full-duplex mode where the high bus carries interleaved receive words and the low bus carries interleaved transmit words.

In the half-duplex modes a direction input picks the active path. The drivers of any bus the port is not driving are switched off, so the two buses can share wires with the far end. A sync output marks which receive channel is on the bus, and a sync input marks the first word of a transmit pair. A pair that breaks the A-then-B order raises a one-cycle error. Each path has its own option to flip the top bit, which converts between offset-binary and twos-complement. A configuration check flags interleaved modes that are paired with a 1x transmit interpolation setting, because those modes need 2x or 4x.

Top module: `cdp_port`

## Requirements
- R1: `mode` is encoded as 0 = 24-bit parallel half-duplex, 1 = 12-bit interleaved half-duplex, 2 = full duplex, and 3 = reserved (behaves as full duplex). `interp` is encoded as 0 = 1x, 1 = 2x, 2 or 3 = 4x. `cfg_err` is high, combinationally, when `mode` is 3, or when `mode` is 1 or 2 and `interp` is 0.
- R2: In the half-duplex modes, `dir` = 0 makes receive active and transmit ignored, and `dir` = 1 makes transmit active and receive ignored. In that second case `adc_vld` has no effect on `bus_hi_o`, `rx_sync` stays low, and both output enables are low. In full duplex both paths are active whatever `dir` is.
- R3: In mode 0 with receive active, a cycle with `adc_vld` high makes the next cycle show channel A on `bus_hi_o` and channel B on `bus_lo_o`, with `rx_sync` high for that one cycle.
- R4: In modes 1, 2 and 3, a receive sample puts channel A on `bus_hi_o` in the next cycle with `rx_sync` high. In the cycle after that it puts channel B there with `rx_sync` low. A new sample that arrives during the B slot takes precedence, and that B word is dropped.
- R5: `bus_hi_oe` is high exactly when receive is active. `bus_lo_oe` is high exactly when receive is active and `mode` is 0.
- R6: In mode 0 with transmit active, a cycle with `tx_vld` high captures `bus_hi_i` as channel A and `bus_lo_i` as channel B. In the next cycle `dac_stb` is high for one cycle with those values on `dac_a` and `dac_b`.
- R7: In the interleaved modes the transmit word is read from `bus_hi_i` in mode 1 and from `bus_lo_i` in modes 2 and 3. A valid word with `tx_sync` = 1 is channel A. The next valid word, with `tx_sync` = 0, is channel B. One cycle after B, `dac_stb` pulses and both channels appear together.
- R8: `tx_err` pulses for one cycle, with `dac_stb` low, in the cycle after either of two events. The first is a valid A word that arrives while an A word is already pending; the new A word replaces the old one. The second is a valid B word that arrives with no A word pending; that B word is discarded.
- R9: With `rx_twos` = 1, bit 11 of each receive word is inverted before it goes onto the bus. With `tx_twos` = 1, bit 11 of each transmit word is inverted before it reaches `dac_a` or `dac_b`.
- R10: A cycle in which a path is inactive drops any half-finished pair on that path: a pending receive B word, or a pending transmit A word.
- R11: After reset, `rx_sync`, `dac_stb` and `tx_err` are low, and `dac_a`, `dac_b`, `bus_hi_o` and `bus_lo_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one clock is one word slot |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Port mode (R1) |
| dir | input | 1 | Half-duplex direction: 0 receive, 1 transmit |
| interp | input | 2 | Transmit interpolation setting, used only for the configuration check |
| rx_twos | input | 1 | Convert receive words to twos-complement |
| tx_twos | input | 1 | Transmit words arrive in twos-complement |
| adc_vld | input | 1 | A new receive sample pair is present |
| adc_a | input | 12 | Receive sample, channel A |
| adc_b | input | 12 | Receive sample, channel B |
| bus_hi_i | input | 12 | High bus, input side |
| bus_lo_i | input | 12 | Low bus, input side |
| bus_hi_o | output | 12 | High bus, output side |
| bus_lo_o | output | 12 | Low bus, output side |
| bus_hi_oe | output | 1 | High bus driver enable |
| bus_lo_oe | output | 1 | Low bus driver enable |
| rx_sync | output | 1 | High while channel A (or the parallel pair) is fresh on the bus |
| tx_vld | input | 1 | A transmit word is on the bus |
| tx_sync | input | 1 | Marks the transmit word as channel A |
| dac_a | output | 12 | Transmit sample, channel A, offset-binary |
| dac_b | output | 12 | Transmit sample, channel B, offset-binary |
| dac_stb | output | 1 | One-cycle strobe: a new transmit pair is ready |
| tx_err | output | 1 | Transmit pairing error pulse |
| cfg_err | output | 1 | Illegal mode or interpolation combination |

## Verification
The hardest cases to reach are those where the pairing state is interrupted partway through. Examples are a receive sample landing in the B slot of the previous sample, a direction flip while a transmit A word is pending, and a mode change between the two halves of a pair. The stimulus keeps sample and word strobes random and dense in every mode. It also toggles `dir`, `tx_sync` and both conversion bits at random, so that these interruptions occur many times in each mode. Directed sequences add a doubled A word and an output check on the conversion of a zero sample.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
   typedef enum logic [1:0] {
      PM_PAR24 = 2'd0,
      PM_IL12  = 2'd1,
      PM_SPLIT = 2'd2,
      PM_RSVD  = 2'd3
   } port_mode_e;

   localparam logic [1:0] INTERP_1X = 2'd0;
endpackage

// File: rtl/cdp_rx_mux.sv
module cdp_rx_mux #(
   parameter int W            = 12,
   parameter bit TWOS_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         par,
   input  logic         twos,
   input  logic         vld,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] hi_q,
   output logic [W-1:0] lo_q,
   output logic         sync
);
   logic [W-1:0] flip, a_c, b_c, b_hold;
   logic         b_pend;

   generate
      if (TWOS_SUPPORT) begin : g_conv
         assign flip = {twos, {(W-1){1'b0}}};
      end else begin : g_noconv
         assign flip = '0;
      end
   endgenerate

   assign a_c = a ^ flip;
   assign b_c = b ^ flip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         b_hold <= '0;
         b_pend <= 1'b0;
         sync   <= 1'b0;
      end else if (!active) begin
         b_pend <= 1'b0;
         sync   <= 1'b0;
      end else if (vld) begin
         hi_q <= a_c;
         sync <= 1'b1;
         if (par) begin
            lo_q   <= b_c;
            b_pend <= 1'b0;
         end else begin
            b_hold <= b_c;
            b_pend <= 1'b1;
         end
      end else begin
         sync <= 1'b0;
         if (b_pend) begin
            hi_q   <= b_hold;
            b_pend <= 1'b0;
         end
      end
   end

   assert_sync_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && vld) |=> sync);
   assert_idle_no_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !sync);
endmodule

// File: rtl/cdp_tx_demux.sv
module cdp_tx_demux #(
   parameter int W            = 12,
   parameter bit TWOS_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         par,
   input  logic         use_lo,
   input  logic         twos,
   input  logic         vld,
   input  logic         sync,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   output logic [W-1:0] da,
   output logic [W-1:0] db,
   output logic         stb,
   output logic         err
);
   logic [W-1:0] flip, word, hold_a;
   logic         pend;

   generate
      if (TWOS_SUPPORT) begin : g_conv
         assign flip = {twos, {(W-1){1'b0}}};
      end else begin : g_noconv
         assign flip = '0;
      end
   endgenerate

   assign word = use_lo ? lo : hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         da     <= '0;
         db     <= '0;
         hold_a <= '0;
         pend   <= 1'b0;
         stb    <= 1'b0;
         err    <= 1'b0;
      end else begin
         stb <= 1'b0;
         err <= 1'b0;
         if (!active) begin
            pend <= 1'b0;
         end else if (vld) begin
            if (par) begin
               da   <= hi ^ flip;
               db   <= lo ^ flip;
               stb  <= 1'b1;
               pend <= 1'b0;
            end else if (sync) begin
               hold_a <= word;
               pend   <= 1'b1;
               err    <= pend;
            end else if (pend) begin
               da   <= hold_a ^ flip;
               db   <= word ^ flip;
               stb  <= 1'b1;
               pend <= 1'b0;
            end else begin
               err <= 1'b1;
            end
         end
      end
   end

   assert_stb_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && err));
   assert_stb_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> $past(vld && active));
endmodule

// File: rtl/cdp_port.sv
module cdp_port
   import cdp_pkg::*;
#(
   parameter int W            = 12,
   parameter bit TWOS_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         dir,
   input  logic [1:0]   interp,
   input  logic         rx_twos,
   input  logic         tx_twos,
   input  logic         adc_vld,
   input  logic [W-1:0] adc_a,
   input  logic [W-1:0] adc_b,
   input  logic [W-1:0] bus_hi_i,
   input  logic [W-1:0] bus_lo_i,
   output logic [W-1:0] bus_hi_o,
   output logic [W-1:0] bus_lo_o,
   output logic         bus_hi_oe,
   output logic         bus_lo_oe,
   output logic         rx_sync,
   input  logic         tx_vld,
   input  logic         tx_sync,
   output logic [W-1:0] dac_a,
   output logic [W-1:0] dac_b,
   output logic         dac_stb,
   output logic         tx_err,
   output logic         cfg_err
);
   generate
      if (W < 4) begin : g_bad_width
         $error("cdp_port: W must be at least 4");
      end
   endgenerate

   port_mode_e pm;
   logic       par, split, rx_act, tx_act;

   assign pm     = port_mode_e'(mode);
   assign par    = (pm == PM_PAR24);
   assign split  = (pm == PM_SPLIT) || (pm == PM_RSVD);
   assign rx_act = split || !dir;
   assign tx_act = split || dir;

   assign bus_hi_oe = rx_act;
   assign bus_lo_oe = rx_act && par;
   assign cfg_err   = (pm == PM_RSVD) || (!par && interp == INTERP_1X);

   cdp_rx_mux #(.W(W), .TWOS_SUPPORT(TWOS_SUPPORT)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (rx_act),
      .par    (par),
      .twos   (rx_twos),
      .vld    (adc_vld),
      .a      (adc_a),
      .b      (adc_b),
      .hi_q   (bus_hi_o),
      .lo_q   (bus_lo_o),
      .sync   (rx_sync)
   );

   cdp_tx_demux #(.W(W), .TWOS_SUPPORT(TWOS_SUPPORT)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (tx_act),
      .par    (par),
      .use_lo (split),
      .twos   (tx_twos),
      .vld    (tx_vld),
      .sync   (tx_sync),
      .hi     (bus_hi_i),
      .lo     (bus_lo_i),
      .da     (dac_a),
      .db     (dac_b),
      .stb    (dac_stb),
      .err    (tx_err)
   );

   assert_lo_oe_par_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_lo_oe |-> (mode == 2'd0));
   assert_shared_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[1] && dir) |-> !(bus_hi_oe || bus_lo_oe));
   assert_cfg_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |-> cfg_err);
endmodule

// File: tb/tb_cdp_port.sv
module tb_cdp_port;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic         dir = 1'b0;
   logic [1:0]   interp = 2'd1;
   logic         rx_twos = 1'b0, tx_twos = 1'b0;
   logic         adc_vld = 1'b0;
   logic [W-1:0] adc_a = '0, adc_b = '0, bus_hi_i = '0, bus_lo_i = '0;
   logic         tx_vld = 1'b0, tx_sync = 1'b0;
   logic [W-1:0] bus_hi_o, bus_lo_o, dac_a, dac_b;
   logic         bus_hi_oe, bus_lo_oe, rx_sync, dac_stb, tx_err, cfg_err;

   int total = 0, bad = 0, cyc = 0;

   always #5 clk = ~clk;

   cdp_port #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .dir(dir), .interp(interp),
      .rx_twos(rx_twos), .tx_twos(tx_twos), .adc_vld(adc_vld),
      .adc_a(adc_a), .adc_b(adc_b), .bus_hi_i(bus_hi_i), .bus_lo_i(bus_lo_i),
      .bus_hi_o(bus_hi_o), .bus_lo_o(bus_lo_o), .bus_hi_oe(bus_hi_oe),
      .bus_lo_oe(bus_lo_oe), .rx_sync(rx_sync), .tx_vld(tx_vld),
      .tx_sync(tx_sync), .dac_a(dac_a), .dac_b(dac_b), .dac_stb(dac_stb),
      .tx_err(tx_err), .cfg_err(cfg_err)
   );

   // reference model state
   logic [W-1:0] e_hi = '0, e_lo = '0, e_da = '0, e_db = '0;
   logic         e_rs = 1'b0, e_stb = 1'b0, e_err = 1'b0;
   logic [W-1:0] rxq[$];
   logic [W-1:0] txa[$];

   function automatic logic [W-1:0] cv(input logic [W-1:0] x, input logic t);
      return t ? {~x[W-1], x[W-2:0]} : x;   // R9: top bit flip
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         e_hi = '0; e_lo = '0; e_da = '0; e_db = '0;
         e_rs = 0; e_stb = 0; e_err = 0;
         rxq.delete(); txa.delete();
      end else begin
         automatic bit rxa = (mode >= 2) || !dir;
         automatic bit txv = (mode >= 2) || dir;
         automatic logic [W-1:0] w = (mode >= 2) ? bus_lo_i : bus_hi_i;
         if (!rxa) begin rxq.delete(); e_rs = 0; end   // R10
         else if (adc_vld) begin
            rxq.delete();
            e_hi = cv(adc_a, rx_twos);
            e_rs = 1;
            if (mode == 0) e_lo = cv(adc_b, rx_twos);
            else rxq.push_back(cv(adc_b, rx_twos));
         end else if (rxq.size() > 0) begin
            e_hi = rxq.pop_front(); e_rs = 0;
         end else e_rs = 0;
         e_stb = 0; e_err = 0;
         if (!txv) txa.delete();
         else if (tx_vld) begin
            if (mode == 0) begin
               e_da = cv(bus_hi_i, tx_twos); e_db = cv(bus_lo_i, tx_twos);
               e_stb = 1; txa.delete();
            end else if (tx_sync) begin
               if (txa.size() > 0) e_err = 1;
               txa.delete(); txa.push_back(w);
            end else if (txa.size() > 0) begin
               e_da = cv(txa.pop_front(), tx_twos); e_db = cv(w, tx_twos); e_stb = 1;
            end else e_err = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit rxa = (mode >= 2) || !dir;
         chk("R1 cfg_err", cfg_err, (mode == 3) || (mode != 0 && interp == 0));
         chk("R2,R5 bus_hi_oe", bus_hi_oe, rxa);
         chk("R5 bus_lo_oe", bus_lo_oe, rxa && mode == 0);
         chk("R3,R4 rx_sync", rx_sync, e_rs);
         if (rxa) chk("R3,R4 bus_hi_o", bus_hi_o, e_hi);
         if (rxa && mode == 0) chk("R3 bus_lo_o", bus_lo_o, e_lo);
         chk("R6,R7 dac_stb", dac_stb, e_stb);
         chk("R8 tx_err", tx_err, e_err);
         if (e_stb) begin
            chk("R6,R7,R9 dac_a", dac_a, e_da);
            chk("R6,R7,R9 dac_b", dac_b, e_db);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      adc_vld = 0; tx_vld = 0; tx_sync = 0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      @(negedge clk);
      chk("R11 rx_sync", rx_sync, 0);
      chk("R11 dac_stb", dac_stb, 0);
      chk("R11 tx_err", tx_err, 0);
      chk("R11 dac_a", dac_a, 0);
      chk("R11 bus_hi_o", bus_hi_o, 0);
      chk("R11 bus_lo_o", bus_lo_o, 0);

      // R9 directed: zero sample with conversion on
      step(); mode = 0; dir = 0; rx_twos = 1; adc_vld = 1; adc_a = '0; adc_b = '1;
      step(); idle();
      @(negedge clk);
      chk("R9 bus_hi_o", bus_hi_o, 12'h800);
      chk("R9 bus_lo_o", bus_lo_o, 12'h7FF);

      // R8 directed: doubled A word, then B completes the newer pair (R7)
      step(); rx_twos = 0; mode = 1; dir = 1; tx_twos = 0;
      tx_vld = 1; tx_sync = 1; bus_hi_i = 12'h111;
      step(); bus_hi_i = 12'h222;
      step(); idle();
      @(negedge clk);
      chk("R8 tx_err doubled A", tx_err, 1);
      step(); tx_vld = 1; tx_sync = 0; bus_hi_i = 12'h333;
      step(); idle();
      @(negedge clk);
      chk("R7 dac_stb", dac_stb, 1);
      chk("R7 dac_a", dac_a, 12'h222);
      chk("R7 dac_b", dac_b, 12'h333);

      // R10 directed: direction flip drops a pending A word
      step(); tx_vld = 1; tx_sync = 1; bus_hi_i = 12'h444;
      step(); idle(); dir = 0;
      step(); dir = 1;
      step(); tx_vld = 1; tx_sync = 0; bus_hi_i = 12'h555;
      step(); idle();
      @(negedge clk);
      chk("R10 tx_err after flush", tx_err, 1);
      chk("R10 dac_stb after flush", dac_stb, 0);

      // random phases in each mode
      for (int m = 0; m < 4; m++) begin
         step(); mode = 2'(m);
         for (int i = 0; i < 3000; i++) begin
            step();
            if ($urandom_range(0, 15) == 0) dir = ~dir;
            if ($urandom_range(0, 31) == 0) rx_twos = ~rx_twos;
            if ($urandom_range(0, 31) == 0) tx_twos = ~tx_twos;
            if ($urandom_range(0, 63) == 0) interp = 2'($urandom_range(0, 3));
            adc_vld  = ($urandom_range(0, 2) == 0);
            adc_a    = 12'($urandom);
            adc_b    = 12'($urandom);
            tx_vld   = ($urandom_range(0, 1) == 0);
            tx_sync  = ($urandom_range(0, 3) != 0) ? ~tx_sync : tx_sync;
            bus_hi_i = 12'($urandom);
            bus_lo_i = 12'($urandom);
         end
         idle();
      end
      repeat (4) step();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule